// File: doc/BRIEF.md
# Word-Packing Serial Receiver with Idle Timeout

This block receives asynchronous serial characters (8 data bits, no parity, one stop bit), gathers them four at a time into 32-bit words and queues the words in a small receive FIFO. The first character of each word lands in bits [7:0], the next in [15:8], and so on. A reader therefore moves four characters per FIFO access instead of one.

A transfer ends in one of two ways. The line stays quiet for a programmable number of bit times, or the byte count reaches a programmed transfer length. Either way the block pushes any half-filled word into the FIFO, with its unused lanes zero. It then latches the number of bytes in the transfer, raises a sticky end-of-transfer flag and disarms itself until software clears the flag and arms it again. From the latched count the reader works out how many lanes of the last word hold data.

Software drives the block through a flat word-wide register port. It issues commands, sets the baud divisor, the idle timeout, the FIFO level watermark and the transfer length, reads status and the byte-count snapshot, and pops words. Sticky overrun and framing-error bits report lost data.

Top module: `wprx_top`

Register map (3-bit address): 0 command (write, reads 0), 1 divisor, 2 idle timeout in bit times, 3 watermark, 4 transfer length, 5 status, 6 byte-count snapshot, 7 FIFO data. Command bits: 0 receiver reset, 1 receiver enable, 2 clear end flag, 3 arm, 4 clear error bits. Status bits: 0 FIFO not empty, 1 end-of-transfer flag, 2 overrun, 3 framing error, 4 receiver enabled, 5 level interrupt, [15:8] FIFO word count.

## Requirements
- R1: Each character is a low start bit, eight data bits sent LSB first, and a high stop bit, each bit lasting 16 ticks of the divisor-generated oversampling clock. A start bit that is no longer low half a bit after its falling edge is discarded and produces no character.
- R2: Character k of a transfer (counting from 0) is placed in lane k mod 4 of a word, where lane j is bits [8j+7:8j]. A word goes into the FIFO as soon as its fourth lane is filled.
- R3: When the block is armed and has received at least one character, and no further character arrives for the programmed number of bit times (timeout register nonzero), the end flag (status bit 1) is set. Any partial word is pushed with its unused lanes zero. A partial word is never pushed otherwise.
- R4: When a transfer ends, the snapshot register takes the number of characters received in that transfer. The byte count then restarts from zero.
- R5: The end flag stays set until command bit 2. Ending a transfer disarms the block, and no further transfer end happens until command bit 3 arms it again. While the block is disarmed, received bytes stay in the partial word.
- R6: With a nonzero transfer length programmed, the character that brings the transfer count to that length ends the transfer in the same way as R3, whether or not the line goes idle.
- R7: Command bit 0 empties the FIFO, drops the partial word and byte count, and disables reception. No character is accepted until command bit 1. When both bits are written together, the reset is applied first.
- R8: A word pushed while the FIFO is full is dropped and sets the sticky overrun bit (status bit 2). Only command bit 4 clears that bit.
- R9: A character whose stop bit samples low is discarded and sets the sticky framing-error bit (status bit 3). Command bit 4 clears that bit.
- R10: irq_level is high while the FIFO word count is at or above a nonzero watermark. A watermark of zero holds it low.
- R11: A read of the data address returns the oldest word and removes it. A read of an empty FIFO returns zero and changes nothing.
- R12: After reset, status, snapshot and data read zero, the divisor reads its default, and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idles high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops when addressing data) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| irq_level | output | 1 | FIFO level at or above the watermark |
| irq_stale | output | 1 | End-of-transfer flag |

## Verification
A register write takes effect at the next clock edge, and read data follows the address in the same cycle, so the bench reads half a cycle after it drives the address. A character becomes visible about three cycles after the mid-stop sample (two synchronizer stages, the deserializer register and the packer register) and one cycle later in the FIFO count. The bench therefore checks only after the whole stop bit has been driven, which is at least 14 cycles past that sample. An idle timeout falls due the programmed number of bit times after the last character. The bench waits well beyond that (700 cycles against a 512-cycle timeout), and the length-triggered end is checked a few cycles after its final stop bit.

// File: rtl/wprx_pkg.sv
package wprx_pkg;

    typedef enum logic [2:0] {
        A_CMD   = 3'd0,
        A_DIV   = 3'd1,
        A_STALE = 3'd2,
        A_WMARK = 3'd3,
        A_XLEN  = 3'd4,
        A_STAT  = 3'd5,
        A_SNAP  = 3'd6,
        A_DATA  = 3'd7
    } reg_addr_e;

    localparam int CMD_RX_RST    = 0;
    localparam int CMD_RX_EN     = 1;
    localparam int CMD_STALE_CLR = 2;
    localparam int CMD_STALE_ARM = 3;
    localparam int CMD_ERR_CLR   = 4;

    localparam int WORD_W  = 32;
    localparam int LANES   = WORD_W / 8;
    localparam int OS_RATE = 16;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_STOP
    } fr_state_e;

endpackage

// File: rtl/wprx_frame.sv
module wprx_frame
    import wprx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rxd,
    input  logic [DIV_W-1:0] div,
    output logic             os_tick,
    output logic             char_vld,
    output logic             frame_err,
    output logic [7:0]       char_data
);

    localparam logic [3:0] MID  = 4'(OS_RATE / 2 - 1);
    localparam logic [3:0] LAST = 4'(OS_RATE - 1);

    typedef struct packed {
        logic [DIV_W-1:0] dcnt;
        logic [1:0]       sync;
        fr_state_e        st;
        logic [3:0]       os;
        logic [2:0]       idx;
        logic [7:0]       sh;
        logic             vld;
        logic             ferr;
    } fr_t;

    fr_t              fr_q, fr_d;
    logic [DIV_W-1:0] div_m1;
    logic             tick;
    logic             line;

    always_comb begin
        div_m1    = (div == '0) ? '0 : div - 1'b1;
        tick      = (fr_q.dcnt >= div_m1);
        line      = fr_q.sync[1];
        fr_d      = fr_q;
        fr_d.vld  = 1'b0;
        fr_d.ferr = 1'b0;
        fr_d.sync = {fr_q.sync[0], rxd};
        fr_d.dcnt = tick ? '0 : fr_q.dcnt + 1'b1;
        if (!en) begin
            fr_d.st  = FR_IDLE;
            fr_d.os  = '0;
            fr_d.idx = '0;
        end else begin
            case (fr_q.st)
                FR_IDLE: begin
                    if (!line) begin
                        fr_d.st = FR_START;
                        fr_d.os = '0;
                    end
                end
                FR_START: begin
                    if (tick) begin
                        if (fr_q.os == MID) begin
                            fr_d.os  = '0;
                            fr_d.idx = '0;
                            fr_d.st  = line ? FR_IDLE : FR_DATA;
                        end else begin
                            fr_d.os = fr_q.os + 4'd1;
                        end
                    end
                end
                FR_DATA: begin
                    if (tick) begin
                        if (fr_q.os == LAST) begin
                            fr_d.os = '0;
                            fr_d.sh = {line, fr_q.sh[7:1]};
                            if (fr_q.idx == 3'd7) fr_d.st = FR_STOP;
                            else                  fr_d.idx = fr_q.idx + 3'd1;
                        end else begin
                            fr_d.os = fr_q.os + 4'd1;
                        end
                    end
                end
                FR_STOP: begin
                    if (tick) begin
                        if (fr_q.os == LAST) begin
                            fr_d.os   = '0;
                            fr_d.st   = FR_IDLE;
                            fr_d.vld  = line;
                            fr_d.ferr = !line;
                        end else begin
                            fr_d.os = fr_q.os + 4'd1;
                        end
                    end
                end
                default: fr_d.st = FR_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '{dcnt: '0, sync: 2'b11, st: FR_IDLE, os: '0, idx: '0,
                      sh: '0, vld: 1'b0, ferr: 1'b0};
        end else begin
            fr_q <= fr_d;
        end
    end

    assign os_tick   = tick;
    assign char_vld  = fr_q.vld;
    assign frame_err = fr_q.ferr;
    assign char_data = fr_q.sh;

endmodule

// File: rtl/wprx_packer.sv
module wprx_packer
    import wprx_pkg::*;
#(
    parameter int TOT_W = 16,
    parameter int STO_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              char_vld,
    input  logic [7:0]        char_data,
    input  logic              os_tick,
    input  logic [STO_W-1:0]  stale_to,
    input  logic [TOT_W-1:0]  xlen,
    input  logic              stale_clr,
    input  logic              stale_arm,
    output logic              push,
    output logic [WORD_W-1:0] push_word,
    output logic              stale_flag,
    output logic              armed,
    output logic [TOT_W-1:0]  snap
);

    localparam int LANE_W = $clog2(LANES);
    localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'(LANES - 1);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [LANE_W-1:0] lane;
        logic [TOT_W-1:0]  total;
        logic              active;
        logic              armed;
        logic              flag;
        logic [TOT_W-1:0]  snap;
        logic [3:0]        sub;
        logic [STO_W-1:0]  bits;
        logic              push;
        logic [WORD_W-1:0] pword;
    } pk_t;

    pk_t               pk_q, pk_d;
    logic [WORD_W-1:0] merged;
    logic [TOT_W-1:0]  tot_n;
    logic              timeout;
    logic              len_hit;

    always_comb begin
        pk_d      = pk_q;
        pk_d.push = 1'b0;
        merged    = pk_q.word;
        merged[{pk_q.lane, 3'b000} +: 8] = char_data;
        tot_n     = pk_q.total + 1'b1;
        timeout   = pk_q.armed && pk_q.active && (stale_to != '0) && (pk_q.bits >= stale_to);
        len_hit   = pk_q.armed && (xlen != '0) && (tot_n == xlen);

        if (os_tick) begin
            pk_d.sub = pk_q.sub + 4'd1;
            if (pk_q.sub == 4'(OS_RATE - 1) && pk_q.bits != '1) begin
                pk_d.bits = pk_q.bits + 1'b1;
            end
        end

        if (char_vld) begin
            pk_d.active = 1'b1;
            pk_d.sub    = '0;
            pk_d.bits   = '0;
            pk_d.total  = tot_n;
            if (pk_q.lane == LANE_LAST || len_hit) begin
                pk_d.push  = 1'b1;
                pk_d.pword = merged;
                pk_d.word  = '0;
                pk_d.lane  = '0;
            end else begin
                pk_d.word = merged;
                pk_d.lane = pk_q.lane + 1'b1;
            end
            if (len_hit) begin
                pk_d.snap   = tot_n;
                pk_d.flag   = 1'b1;
                pk_d.armed  = 1'b0;
                pk_d.active = 1'b0;
                pk_d.total  = '0;
            end
        end else if (timeout) begin
            if (pk_q.lane != '0) begin
                pk_d.push  = 1'b1;
                pk_d.pword = pk_q.word;
            end
            pk_d.word   = '0;
            pk_d.lane   = '0;
            pk_d.snap   = pk_q.total;
            pk_d.flag   = 1'b1;
            pk_d.armed  = 1'b0;
            pk_d.active = 1'b0;
            pk_d.total  = '0;
        end

        if (stale_clr) pk_d.flag  = 1'b0;
        if (stale_arm) pk_d.armed = 1'b1;

        if (clr) begin
            pk_d.word   = '0;
            pk_d.lane   = '0;
            pk_d.total  = '0;
            pk_d.active = 1'b0;
            pk_d.sub    = '0;
            pk_d.bits   = '0;
            pk_d.push   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign push       = pk_q.push;
    assign push_word  = pk_q.pword;
    assign stale_flag = pk_q.flag;
    assign armed      = pk_q.armed;
    assign snap       = pk_q.snap;

endmodule

// File: rtl/wprx_fifo.sv
module wprx_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [DW-1:0]    wdata,
    input  logic             pop,
    output logic [DW-1:0]    rdata,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0]    PTR_LAST = PW'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CNT_W-1:0]         cnt;
    } ff_t;

    ff_t  ff_q, ff_d;
    logic do_push, do_pop;

    always_comb begin
        full    = (ff_q.cnt == CNT_FULL);
        empty   = (ff_q.cnt == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        ff_d    = ff_q;
        if (do_push) begin
            ff_d.mem[ff_q.wp] = wdata;
            ff_d.wp = (ff_q.wp == PTR_LAST) ? '0 : ff_q.wp + 1'b1;
        end
        if (do_pop) begin
            ff_d.rp = (ff_q.rp == PTR_LAST) ? '0 : ff_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   ff_d.cnt = ff_q.cnt + 1'b1;
            2'b01:   ff_d.cnt = ff_q.cnt - 1'b1;
            default: ff_d.cnt = ff_q.cnt;
        endcase
        if (clr) begin
            ff_d.wp  = '0;
            ff_d.rp  = '0;
            ff_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= ff_d;
    end

    assign rdata = ff_q.mem[ff_q.rp];
    assign count = ff_q.cnt;

endmodule

// File: rtl/wprx_top.sv
module wprx_top
    import wprx_pkg::*;
#(
    parameter int DIV_W    = 16,
    parameter int DIV_INIT = 16,
    parameter int DEPTH    = 8,
    parameter int TOT_W    = 16,
    parameter int STO_W    = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rxd,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq_level,
    output logic        irq_stale
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [STO_W-1:0] sto;
        logic [CNT_W-1:0] wm;
        logic [TOT_W-1:0] xlen;
        logic             rx_en;
        logic             ovr;
        logic             ferr;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic              cmd_wr, c_rst, c_en, c_sclr, c_sarm, c_eclr;
    logic              fr_en, os_tick, char_vld, frame_err;
    logic [7:0]        char_data;
    logic              pk_push, stale_flag, armed;
    logic [WORD_W-1:0] pk_word;
    logic [TOT_W-1:0]  snap;
    logic              ff_pop, ff_full, ff_empty;
    logic [WORD_W-1:0] ff_rdata;
    logic [CNT_W-1:0]  ff_cnt;
    logic              rx_en, ovr, ferr;

    always_comb begin
        cmd_wr = reg_wr && (reg_addr == A_CMD);
        c_rst  = cmd_wr && reg_wdata[CMD_RX_RST];
        c_en   = cmd_wr && reg_wdata[CMD_RX_EN];
        c_sclr = cmd_wr && reg_wdata[CMD_STALE_CLR];
        c_sarm = cmd_wr && reg_wdata[CMD_STALE_ARM];
        c_eclr = cmd_wr && reg_wdata[CMD_ERR_CLR];
        ff_pop = reg_rd && (reg_addr == A_DATA);
        fr_en  = ctl_q.rx_en && !c_rst;

        ctl_d = ctl_q;
        if (c_rst) ctl_d.rx_en = 1'b0;
        if (c_en)  ctl_d.rx_en = 1'b1;
        if (pk_push && ff_full) ctl_d.ovr  = 1'b1;
        if (frame_err)          ctl_d.ferr = 1'b1;
        if (c_eclr) begin
            ctl_d.ovr  = 1'b0;
            ctl_d.ferr = 1'b0;
        end
        if (reg_wr) begin
            case (reg_addr)
                A_DIV:   ctl_d.div  = reg_wdata[DIV_W-1:0];
                A_STALE: ctl_d.sto  = reg_wdata[STO_W-1:0];
                A_WMARK: ctl_d.wm   = reg_wdata[CNT_W-1:0];
                A_XLEN:  ctl_d.xlen = reg_wdata[TOT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{div: DIV_W'(DIV_INIT), sto: '0, wm: '0, xlen: '0,
                       rx_en: 1'b0, ovr: 1'b0, ferr: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_DIV:   reg_rdata[DIV_W-1:0] = ctl_q.div;
            A_STALE: reg_rdata[STO_W-1:0] = ctl_q.sto;
            A_WMARK: reg_rdata[CNT_W-1:0] = ctl_q.wm;
            A_XLEN:  reg_rdata[TOT_W-1:0] = ctl_q.xlen;
            A_STAT: begin
                reg_rdata[0]           = !ff_empty;
                reg_rdata[1]           = stale_flag;
                reg_rdata[2]           = ctl_q.ovr;
                reg_rdata[3]           = ctl_q.ferr;
                reg_rdata[4]           = ctl_q.rx_en;
                reg_rdata[5]           = irq_level;
                reg_rdata[8 +: CNT_W]  = ff_cnt;
            end
            A_SNAP:  reg_rdata[TOT_W-1:0] = snap;
            A_DATA:  reg_rdata = ff_empty ? '0 : ff_rdata;
            default: reg_rdata = '0;
        endcase
    end

    assign irq_level = (ctl_q.wm != '0) && (ff_cnt >= ctl_q.wm);
    assign irq_stale = stale_flag;
    assign rx_en     = ctl_q.rx_en;
    assign ovr       = ctl_q.ovr;
    assign ferr      = ctl_q.ferr;

    wprx_frame #(.DIV_W(DIV_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (fr_en),
        .rxd       (rxd),
        .div       (ctl_q.div),
        .os_tick   (os_tick),
        .char_vld  (char_vld),
        .frame_err (frame_err),
        .char_data (char_data)
    );

    wprx_packer #(.TOT_W(TOT_W), .STO_W(STO_W)) u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (c_rst),
        .char_vld   (char_vld),
        .char_data  (char_data),
        .os_tick    (os_tick),
        .stale_to   (ctl_q.sto),
        .xlen       (ctl_q.xlen),
        .stale_clr  (c_sclr),
        .stale_arm  (c_sarm),
        .push       (pk_push),
        .push_word  (pk_word),
        .stale_flag (stale_flag),
        .armed      (armed),
        .snap       (snap)
    );

    wprx_fifo #(.DW(WORD_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (c_rst),
        .push  (pk_push),
        .wdata (pk_word),
        .pop   (ff_pop),
        .rdata (ff_rdata),
        .count (ff_cnt),
        .full  (ff_full),
        .empty (ff_empty)
    );

endmodule

// File: rtl/wprx_chk.sv
module wprx_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_en,
    input logic             char_vld,
    input logic             frame_err,
    input logic             pk_push,
    input logic             ff_full,
    input logic             ff_pop,
    input logic [CNT_W-1:0] ff_cnt,
    input logic             ovr,
    input logic             err_clr,
    input logic             stale_flag,
    input logic             stale_clr,
    input logic             armed
);

    assert_fifo_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ff_cnt <= CNT_W'(DEPTH));

    assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pk_push && ff_full && !err_clr |=> ovr);

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovr && !err_clr |=> ovr);

    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !char_vld);

    assert_char_or_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({char_vld, frame_err}));

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stale_flag && !stale_clr |=> stale_flag);

    assert_end_needs_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stale_flag) |-> $past(armed));

    assert_empty_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ff_pop && (ff_cnt == '0) && !pk_push |=> (ff_cnt == '0));

endmodule

bind wprx_top wprx_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .char_vld   (char_vld),
    .frame_err  (frame_err),
    .pk_push    (pk_push),
    .ff_full    (ff_full),
    .ff_pop     (ff_pop),
    .ff_cnt     (ff_cnt),
    .ovr        (ovr),
    .err_clr    (c_eclr),
    .stale_flag (stale_flag),
    .stale_clr  (c_sclr),
    .armed      (armed)
);

// File: tb/tb_wprx_top.sv
module tb_wprx_top;

    localparam int DIVV = 2;
    localparam int BITC = 16 * DIVV;
    localparam int NVEC = 5;
    // {count[43:40], byte4 .. byte0}; byte0 is sent first
    localparam logic [43:0] VEC [NVEC] = '{
        44'h1_00_00_00_00_A5,
        44'h3_00_00_33_22_11,
        44'h4_00_EF_BE_AD_DE,
        44'h5_05_04_03_02_01,
        44'h2_00_00_00_FF_00
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rxd = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_level;
    logic        irq_stale;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wprx_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd       (rxd),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_level (irq_level),
        .irq_stale (irq_stale)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = v;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic pop(output logic [31:0] v);
        @(negedge clk);
        reg_addr = 3'd7;
        reg_rd   = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input bit stop_ok);
        @(negedge clk);
        rxd = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (BITC) @(negedge clk);
        end
        if (stop_ok) begin
            rxd = 1'b1;
            repeat (BITC) @(negedge clk);
        end else begin
            rxd = 1'b0;
            repeat (12 * DIVV) @(negedge clk);
            rxd = 1'b1;
            repeat (BITC) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] s;
        logic [31:0] r;
        logic [31:0] e;
        int n;
        int nw;

        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R12 reset state
        peek(3'd5, s); check("R12 status after reset", s, 32'h0);
        peek(3'd6, s); check("R12 snapshot after reset", s, 32'h0);
        peek(3'd1, s); check("R12 divisor default", s, 32'd16);
        check("R12 interrupts low", {30'b0, irq_level, irq_stale}, 32'h0);
        pop(r);        check("R11 empty read returns zero", r, 32'h0);
        peek(3'd5, s); check("R11 empty read leaves count", s[15:8], 32'h0);

        wr(3'd1, DIVV);
        wr(3'd2, 32'd16);

        // vector table: R2 packing, R3 idle end, R4 snapshot
        for (int v = 0; v < NVEC; v++) begin
            n = int'(VEC[v][43:40]);
            wr(3'd0, 32'h3);
            wr(3'd0, 32'hC);
            for (int i = 0; i < n; i++) send(VEC[v][8*i +: 8], 1'b1);
            idle(700);
            peek(3'd5, s);
            check("R3 end flag after idle", s[1], 32'h1);
            nw = (n + 3) / 4;
            check("R2 word count", s[15:8], nw);
            peek(3'd6, s);
            check("R4 snapshot bytes", s, n);
            for (int j = 0; j < nw; j++) begin
                e = '0;
                for (int l = 0; l < 4; l++) begin
                    if (4 * j + l < n) e[8*l +: 8] = VEC[v][8*(4*j+l) +: 8];
                end
                pop(r);
                check("R2 R3 packed word", r, e);
            end
            peek(3'd5, s);
            check("R11 drained", s[0], 32'h0);
        end

        // R1 short glitch rejected, then a real byte decodes
        wr(3'd0, 32'h3);
        wr(3'd0, 32'hC);
        @(negedge clk);
        rxd = 1'b0;
        repeat (6) @(negedge clk);
        rxd = 1'b1;
        idle(400);
        peek(3'd5, s);
        check("R1 glitch yields no word", s[15:8], 32'h0);
        check("R1 glitch no framing error", s[3], 32'h0);
        send(8'h3C, 1'b1);
        idle(700);
        pop(r);
        check("R1 byte after glitch", r, 32'h0000_003C);

        // R7 reset without enable ignores input
        wr(3'd0, 32'h1);
        peek(3'd5, s);
        check("R7 disabled after reset", s[4], 32'h0);
        send(8'h77, 1'b1);
        idle(700);
        peek(3'd5, s);
        check("R7 no word while disabled", s[15:8], 32'h0);
        // R7 reset drops partial word
        wr(3'd0, 32'h3);
        wr(3'd0, 32'hC);
        send(8'h12, 1'b1);
        send(8'h34, 1'b1);
        wr(3'd0, 32'h3);
        idle(700);
        peek(3'd5, s);
        check("R7 partial dropped", s[15:8], 32'h0);
        check("R7 no end after reset", s[1], 32'h0);
        check("R7 re-enabled by combined write", s[4], 32'h1);

        // R9 framing error
        send(8'h55, 1'b0);
        idle(700);
        peek(3'd5, s);
        check("R9 framing bit set", s[3], 32'h1);
        check("R9 char discarded", s[15:8], 32'h0);
        wr(3'd0, 32'h10);
        peek(3'd5, s);
        check("R9 framing bit cleared", s[3], 32'h0);

        // R5 end flag and re-arm
        wr(3'd0, 32'h3);
        wr(3'd0, 32'hC);
        send(8'h5A, 1'b1);
        idle(700);
        peek(3'd5, s); check("R5 first end", s[1], 32'h1);
        check("R5 interrupt pin", {31'b0, irq_stale}, 32'h1);
        pop(r);        check("R5 first word", r, 32'h0000_005A);
        send(8'h66, 1'b1);
        idle(700);
        peek(3'd5, s); check("R5 no flush while disarmed", s[15:8], 32'h0);
        wr(3'd0, 32'h4);
        peek(3'd5, s); check("R5 flag cleared", s[1], 32'h0);
        idle(700);
        peek(3'd5, s); check("R5 still no flush before arm", s[15:8], 32'h0);
        wr(3'd0, 32'h8);
        idle(20);
        peek(3'd5, s); check("R5 end after arm", s[1], 32'h1);
        peek(3'd6, s); check("R5 snapshot after arm", s, 32'd1);
        pop(r);        check("R5 flushed word", r, 32'h0000_0066);

        // R6 length-terminated transfer
        wr(3'd0, 32'h3);
        wr(3'd0, 32'hC);
        wr(3'd2, 32'd0);
        wr(3'd4, 32'd6);
        for (int i = 0; i < 6; i++) send(8'(8'h11 * (i + 1)), 1'b1);
        idle(4);
        peek(3'd5, s);
        check("R6 end on length", s[1], 32'h1);
        check("R6 word count", s[15:8], 32'd2);
        peek(3'd6, s); check("R6 snapshot", s, 32'd6);
        pop(r);        check("R6 word0", r, 32'h4433_2211);
        pop(r);        check("R6 word1", r, 32'h0000_6655);
        wr(3'd4, 32'd0);
        wr(3'd2, 32'd16);

        // R10 watermark and R8 overrun
        wr(3'd0, 32'h3);
        wr(3'd0, 32'hC);
        wr(3'd3, 32'd2);
        for (int i = 0; i < 4; i++) send(8'(8'h10 + i), 1'b1);
        idle(4);
        check("R10 below watermark", {31'b0, irq_level}, 32'h0);
        for (int i = 4; i < 8; i++) send(8'(8'h10 + i), 1'b1);
        idle(4);
        check("R10 at watermark", {31'b0, irq_level}, 32'h1);
        for (int i = 8; i < 36; i++) send(8'(8'h10 + i), 1'b1);
        idle(4);
        peek(3'd5, s);
        check("R8 overrun set", s[2], 32'h1);
        check("R8 fifo full count", s[15:8], 32'd8);
        pop(r);
        check("R8 oldest word kept", r, 32'h1312_1110);
        wr(3'd0, 32'h10);
        peek(3'd5, s);
        check("R8 overrun cleared", s[2], 32'h0);
        wr(3'd3, 32'd0);
        idle(2);
        check("R10 zero watermark disables", {31'b0, irq_level}, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule